// File: doc/BRIEF.md
# Low-Power Column Precharge Controller

This block drives one active-low precharge enable for each column of a bit-oriented SRAM array. In functional mode every column's enable follows a single global precharge signal, so the whole array is restored each cycle. In the low-power test mode the test sequencer is assumed to step through the array one row at a time, column after column. Only two columns then need their bit lines charged: the column being accessed and the column that will be accessed next. All other columns keep precharge off. This reduces the read-equivalent stress on cells that share the word line, and it also saves precharge power.

The accessed column always keeps functional-style timing. Its precharge is released during the first half of the cycle, when the access happens, and re-applied during the second half to restore the bit line. A half-cycle phase input marks the two halves. When the last cell of a row is accessed, the sequencer raises an end-of-row flag. The controller registers that flag and runs the following cycle in functional mode, so that every bit line is back at full level before the next row begins.

Top module: `lp_precharge_ctrl`

## Requirements
- R1: Every output bit is active low: 0 means the column's precharge is on and 1 means it is off. After reset the fallback state is clear, so the test-mode rules below apply from the first cycle.
- R2: While `test_lp` is 0, every bit of `pre_n` equals `pre_n_glb`.
- R3: In test mode, when `col_sel[j]` is 1 and j is below COLS-1, `pre_n[j+1]` is 0 for the whole cycle, in either phase.
- R4: In test mode, the selected column's `pre_n` bit is 1 while `phase_late` is 0 (access half) and 0 while `phase_late` is 1 (restore half).
- R5: In test mode with a column selected, every column that is neither the selected one nor the one after it has `pre_n` at 1.
- R6: When the last column (index COLS-1) is selected in test mode, `pre_n[0]` stays 1. Selection does not wrap around.
- R7: When `row_done` is 1 at a rising clock edge, the next cycle behaves as functional mode: all outputs equal `pre_n_glb` regardless of `test_lp`. The cycle after that returns to test-mode behaviour unless `row_done` was 1 again.
- R8: In test mode with no column selected (`col_sel` all zero), every bit of `pre_n` is 0.
- R9: While `rst_n` is 0 the registered fallback is cleared, so an end-of-row flag seen during reset has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pre_n_glb | input | 1 | Global precharge, active low |
| phase_late | input | 1 | 1 during the second half of the cycle |
| col_sel | input | COLS | One-hot column select, active high |
| test_lp | input | 1 | 1 selects the low-power test mode |
| row_done | input | 1 | Final access of the current row |
| pre_n | output | COLS | Per-column precharge enable, active low |

## Verification
The assertions check the following on every cycle: outputs follow the global signal outside test mode, and the forced functional cycle follows each end-of-row flag. In test mode with a one-hot select, at most two columns are ever precharged. With nothing selected, every column is precharged. The column after the selected one is held on, and the last column never reaches column 0. The phase timing of the selected column, the exact off state of every unrelated column, and the return to test behaviour after the fallback cycle are shown by the bench. It sweeps every select position, phase, global level and mode of an eight-column instance.

// File: rtl/lp_precharge_ctrl.sv
module lp_precharge_ctrl #(
  parameter int COLS = 512
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pre_n_glb,
  input  logic            phase_late,
  input  logic [COLS-1:0] col_sel,
  input  logic            test_lp,
  input  logic            row_done,
  output logic [COLS-1:0] pre_n
);

  logic            restore_q;
  logic            func_mode;
  logic            any_sel;
  logic [COLS-1:0] next_col;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) restore_q <= 1'b0;
    else        restore_q <= row_done;

  assign func_mode = ~test_lp | restore_q;
  assign any_sel   = |col_sel;
  assign next_col  = {col_sel[COLS-2:0], 1'b0};

  for (genvar j = 0; j < COLS; j++) begin : g_col
    assign pre_n[j] = func_mode   ? pre_n_glb   :
                      !any_sel    ? 1'b0        :
                      col_sel[j]  ? ~phase_late :
                      next_col[j] ? 1'b0        : 1'b1;
  end

endmodule

// File: rtl/lp_precharge_chk.sv
module lp_precharge_chk #(
  parameter int COLS = 512
) (
  input logic            clk,
  input logic            rst_n,
  input logic            pre_n_glb,
  input logic [COLS-1:0] col_sel,
  input logic            test_lp,
  input logic            row_done,
  input logic [COLS-1:0] pre_n
);

  logic seen_end;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) seen_end <= 1'b0;
    else        seen_end <= row_done;

  AST_FUNC_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    !test_lp |-> pre_n == {COLS{pre_n_glb}}); // R2

  AST_ROW_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
    row_done |=> pre_n == {COLS{pre_n_glb}}); // R7

  AST_TWO_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (test_lp && !seen_end && $onehot(col_sel)) |-> $countones(~pre_n) <= 2); // R5

  AST_IDLE_ALL_ON: assert property (@(posedge clk) disable iff (!rst_n)
    (test_lp && !seen_end && col_sel == '0) |-> pre_n == '0); // R8

  AST_NEXT_ON: assert property (@(posedge clk) disable iff (!rst_n)
    (test_lp && !seen_end && col_sel == {{(COLS-1){1'b0}}, 1'b1}) |-> !pre_n[1]); // R3

  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (test_lp && !seen_end && col_sel == {1'b1, {(COLS-1){1'b0}}}) |-> pre_n[0]); // R6

endmodule

bind lp_precharge_ctrl lp_precharge_chk #(.COLS(COLS)) u_chk (
  .clk(clk), .rst_n(rst_n), .pre_n_glb(pre_n_glb), .col_sel(col_sel),
  .test_lp(test_lp), .row_done(row_done), .pre_n(pre_n)
);

// File: tb/tb_lp_precharge_ctrl.sv
module tb_lp_precharge_ctrl;
  localparam int COLS = 8;
  localparam time CLK_PERIOD = 10ns;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            pre_n_glb = 1'b1;
  logic            phase_late = 1'b0;
  logic [COLS-1:0] col_sel = '0;
  logic            test_lp = 1'b1;
  logic            row_done = 1'b0;
  logic [COLS-1:0] pre_n;

  int checks = 0;
  int errors = 0;

  lp_precharge_ctrl #(.COLS(COLS)) dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [COLS-1:0] model(input logic fb, input logic tm,
      input logic g, input logic ph, input int sel);
    logic [COLS-1:0] v;
    if (!tm || fb) return {COLS{g}};
    if (sel < 0) return '0;
    v = '1;
    v[sel] = ~ph;
    if (sel + 1 < COLS) v[sel+1] = 1'b0;
    return v;
  endfunction

  task automatic check(input string req, input logic [COLS-1:0] exp);
    checks++;
    if (pre_n !== exp) begin
      errors++;
      $display("FAIL %s: pre_n=%b expected=%b", req, pre_n, exp);
    end
  endtask

  task automatic drive(input logic tm, input logic g, input logic ph,
      input int sel, input logic rd);
    @(negedge clk);
    test_lp = tm; pre_n_glb = g; phase_late = ph; row_done = rd;
    col_sel = (sel < 0) ? '0 : (COLS'(1) << sel);
    #1;
  endtask

  initial begin
    #(CLK_PERIOD*2000);
    errors++;
    $display("FAIL watchdog: run did not complete");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R9: end-of-row during reset must not force functional mode
    test_lp = 1'b1; row_done = 1'b1; pre_n_glb = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk); row_done = 1'b0; #1;
    check("R9", '0);
    rst_n = 1'b1;
    // R1: reset state in test mode, idle select -> all active-low on
    drive(1, 1, 0, -1, 0);
    check("R1", '0);

    // full sweep: R2 R3 R4 R5 R6 R8
    for (int tm = 0; tm < 2; tm++)
      for (int g = 0; g < 2; g++)
        for (int ph = 0; ph < 2; ph++)
          for (int s = -1; s < COLS; s++) begin
            drive(tm[0], g[0], ph[0], s, 0);
            if (!tm[0])       check("R2", model(0, 0, g[0], ph[0], s));
            else if (s < 0)   check("R8", model(0, 1, g[0], ph[0], s));
            else if (s == COLS-1) check("R6", model(0, 1, g[0], ph[0], s));
            else              check("R3/R4/R5", model(0, 1, g[0], ph[0], s));
          end

    // R7: end-of-row on last column, fallback next cycle, then resume
    drive(1, 0, 0, COLS-1, 1);
    check("R7", model(0, 1, 0, 0, COLS-1));
    drive(1, 0, 1, 0, 0);
    check("R7", {COLS{1'b0}});
    drive(1, 1, 1, 0, 0);
    check("R7", model(0, 1, 1, 1, 0));
    // R7 with global off during fallback
    drive(1, 1, 0, 3, 1);
    check("R7", model(0, 1, 1, 0, 3));
    drive(1, 1, 0, 3, 1);
    check("R7", {COLS{1'b1}});
    drive(1, 1, 0, 3, 0);
    check("R7", {COLS{1'b1}});
    drive(1, 1, 0, 3, 0);
    check("R7", model(0, 1, 1, 0, 3));

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule